// File: doc/BRIEF.md
# Memory write protection controller

This block decides whether a write to a serial memory's array or to its status register may go ahead. It keeps a write-enable latch, a two-bit block-protect setting that guards the top quarter, the top half or the whole array, and an enable bit that decides whether an external active-low lock pin guards the status register at all. A command decoder feeds it enable and disable commands, status write commits and array write requests with their address. It answers each request with a one-cycle grant or deny pulse and provides a status readback word.

The lock pin only ever guards the status register. When the lock-enable bit is clear, the pin is ignored completely, so a board that ties it low can still rewrite the status register. While a status write frame is open, a low level on the pin in any cycle of that frame, with the lock-enable bit set, cancels the write. Once a commit has been granted, the status fields hold their new values whatever the pin does next. The busy input stands for the self-timed programming cycle. While it is high, every write is refused. When it falls, the write-enable latch is cleared.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, the status readback is 0x00 when busy is low, and all four grant and deny outputs are low.
- R2: A write-enable command sets the latch, which is status bit 1. A write-disable command clears it. When both arrive in the same cycle, the disable wins.
- R3: With the latch clear, every array request and every status commit is denied.
- R4: Block-protect setting 0 protects nothing, 1 protects 0x3000–0x3FFF, 2 protects 0x2000–0x3FFF and 3 protects the whole array. An array write inside the protected range is denied, and one outside it is granted.
- R5: While busy is high, every array request and every status commit is denied.
- R6: A falling edge on busy clears the write-enable latch. This clear takes priority over an enable command in the same cycle.
- R7: With the lock-enable bit (status bit 7) set and the lock pin low at commit, a status write is denied.
- R8: With the lock-enable bit clear, the lock pin has no effect, and a status write is granted with the pin held low.
- R9: With the lock-enable bit set, a low pin in any cycle of an open status frame denies that frame's commit, even if the pin is high again by then.
- R10: After a status write has been granted, a falling lock pin leaves the written status fields unchanged.
- R11: The lock pin never affects array write decisions.
- R12: Each request produces exactly one of grant or deny, one cycle after it. A granted status write loads data bit 7 into the lock-enable bit and data bits 3:2 into the block-protect field, which are status bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_n | input | 1 | External lock pin, active low |
| busy | input | 1 | Programming cycle in progress |
| frame_active | input | 1 | High while a status write frame is open |
| cmd_wr_en | input | 1 | Write-enable command pulse |
| cmd_wr_dis | input | 1 | Write-disable command pulse |
| sr_commit | input | 1 | Status write commit pulse |
| sr_data | input | 8 | Status data being written |
| arr_req | input | 1 | Array write request pulse |
| arr_addr | input | ADDR_W | Array write address |
| arr_grant | output | 1 | Array write granted |
| arr_deny | output | 1 | Array write denied |
| sr_grant | output | 1 | Status write granted |
| sr_deny | output | 1 | Status write denied |
| status_rd | output | 8 | Status readback: bit7 lock enable, 3:2 protect, 1 latch, 0 busy |

## Verification
The bench builds the block with its default 14-bit address width. This width puts the protect boundaries at 0x1FFF/0x2000 and 0x2FFF/0x3000, together with the ends of the array at 0x0000 and 0x3FFF, within direct reach of the test addresses. Each block-protect setting is tested on both sides of its boundary. The lock pin is driven low at the commit, earlier in an open frame, and after a granted commit, with the lock-enable bit both set and clear.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'd0,
    PROT_QUARTER = 2'd1,
    PROT_HALF    = 2'd2,
    PROT_ALL     = 2'd3
  } prot_e;

  localparam int SR_W        = 8;
  localparam int SR_BUSY_BIT = 0;
  localparam int SR_WEL_BIT  = 1;
  localparam int SR_BP_LO    = 2;
  localparam int SR_LOCK_BIT = 7;

  function automatic logic [SR_W-1:0] pack_status(logic lock_en, prot_e bp,
                                                   logic wel, logic bsy);
    logic [SR_W-1:0] s;
    s = '0;
    s[SR_LOCK_BIT]         = lock_en;
    s[SR_BP_LO+1:SR_BP_LO] = bp;
    s[SR_WEL_BIT]          = wel;
    s[SR_BUSY_BIT]         = bsy;
    return s;
  endfunction
endpackage

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic cmd_wr_en,
  input  logic cmd_wr_dis,
  output logic wel
);
  logic busy_q, wel_q, wel_d, busy_fall;

  assign busy_fall = busy_q & ~busy;

  always_comb begin
    wel_d = wel_q;
    if (cmd_wr_en)              wel_d = 1'b1;
    if (cmd_wr_dis || busy_fall) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      busy_q <= busy;
    end
  end

  assign wel = wel_q;

  assert_wel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !wel);
  assert_dis_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_dis |=> !wel);
endmodule

// File: rtl/wprot_range_chk.sv
module wprot_range_chk
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  prot_e             bp,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;
  logic [1:0] top2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top2 = addr[TOP:TOP-1];
    end else begin : g_narrow
      assign top2 = {addr[TOP], addr[TOP]};
    end
  endgenerate

  always_comb begin
    unique case (bp)
      PROT_NONE:    hit = 1'b0;
      PROT_QUARTER: hit = (top2 == 2'b11);
      PROT_HALF:    hit = top2[1];
      default:      hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_sr_ctl.sv
module wprot_sr_ctl
  import wprot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_n,
  input  logic            busy,
  input  logic            wel,
  input  logic            frame_active,
  input  logic            sr_commit,
  input  logic [SR_W-1:0] sr_data,
  output logic            sr_grant,
  output logic            sr_deny,
  output logic            lock_en,
  output prot_e           bp
);
  logic  abort_q, abort_d;
  logic  lock_en_q, lock_en_d;
  prot_e bp_q, bp_d;
  logic  grant_q, deny_q, grant_d, deny_d;
  logic  pin_blocks, ok;

  assign pin_blocks = lock_en_q & ~lock_n;
  assign ok = wel & ~busy & ~pin_blocks & ~abort_q;

  always_comb begin
    abort_d   = abort_q;
    lock_en_d = lock_en_q;
    bp_d      = bp_q;
    grant_d   = sr_commit & ok;
    deny_d    = sr_commit & ~ok;
    if (!frame_active)   abort_d = 1'b0;
    else if (pin_blocks) abort_d = 1'b1;
    if (grant_d) begin
      lock_en_d = sr_data[SR_LOCK_BIT];
      bp_d      = prot_e'(sr_data[SR_BP_LO+1:SR_BP_LO]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q   <= 1'b0;
      lock_en_q <= 1'b0;
      bp_q      <= PROT_NONE;
      grant_q   <= 1'b0;
      deny_q    <= 1'b0;
    end else begin
      abort_q   <= abort_d;
      lock_en_q <= lock_en_d;
      bp_q      <= bp_d;
      grant_q   <= grant_d;
      deny_q    <= deny_d;
    end
  end

  assign sr_grant = grant_q;
  assign sr_deny  = deny_q;
  assign lock_en  = lock_en_q;
  assign bp       = bp_q;

  assert_lock_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit && lock_en && !lock_n |=> !sr_grant);
  assert_sr_nowel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit && !wel |=> sr_deny);
  assert_sr_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_grant, sr_deny}));
  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_commit |=> $stable(lock_en) && $stable(bp));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_n,
  input  logic              busy,
  input  logic              frame_active,
  input  logic              cmd_wr_en,
  input  logic              cmd_wr_dis,
  input  logic              sr_commit,
  input  logic [7:0]        sr_data,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic              sr_grant,
  output logic              sr_deny,
  output logic [7:0]        status_rd
);
  logic  wel, lock_en, in_prot;
  prot_e bp;
  logic  agrant_q, adeny_q, agrant_d, adeny_d, arr_ok;

  wprot_wel u_wel (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis), .wel(wel)
  );

  wprot_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .addr(arr_addr), .bp(bp), .hit(in_prot)
  );

  wprot_sr_ctl u_sr (
    .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .busy(busy), .wel(wel),
    .frame_active(frame_active), .sr_commit(sr_commit), .sr_data(sr_data),
    .sr_grant(sr_grant), .sr_deny(sr_deny), .lock_en(lock_en), .bp(bp)
  );

  assign arr_ok = wel & ~busy & ~in_prot;

  always_comb begin
    agrant_d = arr_req & arr_ok;
    adeny_d  = arr_req & ~arr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agrant_q <= 1'b0;
      adeny_q  <= 1'b0;
    end else begin
      agrant_q <= agrant_d;
      adeny_q  <= adeny_d;
    end
  end

  assign arr_grant = agrant_q;
  assign arr_deny  = adeny_q;
  assign status_rd = pack_status(lock_en, bp, wel, busy);

  assert_arr_nowel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !wel |=> arr_deny);
  assert_busy_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && busy |=> !arr_grant);
  assert_all_prot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && bp == PROT_ALL |=> !arr_grant);
  assert_arr_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_grant, arr_deny}));
endmodule

// File: tb/wprot_ctrl_tb_top.sv
`timescale 1ns/1ps
module wprot_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_n = 1'b1, busy = 1'b0, frame_active = 1'b0;
  logic cmd_wr_en = 1'b0, cmd_wr_dis = 1'b0, sr_commit = 1'b0, arr_req = 1'b0;
  logic [7:0] sr_data = 8'h00;
  logic [13:0] arr_addr = '0;
  logic arr_grant, arr_deny, sr_grant, sr_deny;
  logic [7:0] status_rd;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  wprot_ctrl #(.ADDR_W(14)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .busy(busy),
    .frame_active(frame_active), .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis),
    .sr_commit(sr_commit), .sr_data(sr_data), .arr_req(arr_req),
    .arr_addr(arr_addr), .arr_grant(arr_grant), .arr_deny(arr_deny),
    .sr_grant(sr_grant), .sr_deny(sr_deny), .status_rd(status_rd)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_en();
    cmd_wr_en = 1'b1; @(negedge clk); cmd_wr_en = 1'b0;
  endtask

  task automatic wr_dis();
    cmd_wr_dis = 1'b1; @(negedge clk); cmd_wr_dis = 1'b0;
  endtask

  // returns {grant,deny}
  task automatic arr_try(input logic [13:0] a, output logic [1:0] r);
    arr_addr = a; arr_req = 1'b1; @(negedge clk);
    r = {arr_grant, arr_deny}; arr_req = 1'b0;
  endtask

  task automatic sr_try(input logic [7:0] d, output logic [1:0] r);
    frame_active = 1'b1; @(negedge clk);
    sr_data = d; sr_commit = 1'b1; @(negedge clk);
    r = {sr_grant, sr_deny}; sr_commit = 1'b0; frame_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status", status_rd, 8'h00);
    check("R1 outputs", {arr_grant, arr_deny, sr_grant, sr_deny}, 4'b0);
  endtask

  task automatic t_wel();
    wr_en(); check("R2 set", status_rd, 8'h02);
    wr_dis(); check("R2 clear", status_rd, 8'h00);
    cmd_wr_en = 1'b1; cmd_wr_dis = 1'b1; @(negedge clk);
    cmd_wr_en = 1'b0; cmd_wr_dis = 1'b0;
    check("R2 both", status_rd, 8'h00);
  endtask

  task automatic t_nowel();
    logic [1:0] r;
    arr_try(14'h0000, r); check("R3 array", r, 2'b01);
    sr_try(8'h00, r);     check("R3 status", r, 2'b01);
  endtask

  task automatic t_prot();
    logic [1:0] r;
    wr_en();
    arr_try(14'h3FFF, r); check("R4 none top", r, 2'b10);
    sr_try(8'h04, r);     check("R12 sr grant", r, 2'b10);
    check("R12 bp1 fields", status_rd, 8'h06);
    arr_try(14'h2FFF, r); check("R4 quarter below", r, 2'b10);
    arr_try(14'h3000, r); check("R4 quarter edge", r, 2'b01);
    sr_try(8'h08, r);     check("R4 set half", r, 2'b10);
    arr_try(14'h1FFF, r); check("R4 half below", r, 2'b10);
    arr_try(14'h2000, r); check("R4 half edge", r, 2'b01);
    sr_try(8'h0C, r);     check("R4 set all", r, 2'b10);
    arr_try(14'h0000, r); check("R4 all low", r, 2'b01);
    sr_try(8'h00, r);     check("R4 back none", r, 2'b10);
  endtask

  task automatic t_busy();
    logic [1:0] r;
    busy = 1'b1; @(negedge clk);
    check("R1 busy bit", status_rd[0], 1'b1);
    arr_try(14'h0010, r); check("R5 array", r, 2'b01);
    sr_try(8'h00, r);     check("R5 status", r, 2'b01);
    busy = 1'b0; cmd_wr_en = 1'b1; @(negedge clk); cmd_wr_en = 1'b0;
    check("R6 fall clears", status_rd, 8'h00);
  endtask

  task automatic t_lock();
    logic [1:0] r;
    wr_en();
    lock_n = 1'b0;
    sr_try(8'h80, r); check("R8 pin ignored", r, 2'b10);
    check("R8 lock en set", status_rd, 8'h82);
    sr_try(8'h80, r); check("R7 pin blocks", r, 2'b01);
    arr_try(14'h0100, r); check("R11 array unaffected", r, 2'b10);
    lock_n = 1'b1;
    frame_active = 1'b1; lock_n = 1'b0; @(negedge clk);
    lock_n = 1'b1; @(negedge clk);
    sr_data = 8'h00; sr_commit = 1'b1; @(negedge clk);
    check("R9 mid-frame abort", {sr_grant, sr_deny}, 2'b01);
    sr_commit = 1'b0; frame_active = 1'b0; @(negedge clk);
    check("R9 fields kept", status_rd, 8'h82);
    sr_try(8'h88, r); check("R9 clean frame", r, 2'b10);
    busy = 1'b1; lock_n = 1'b0; @(negedge clk); @(negedge clk);
    check("R10 fields after pin fall", status_rd, 8'h8B);
    busy = 1'b0; @(negedge clk);
    check("R6 latch cleared", status_rd, 8'h88);
    lock_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    t_reset();
    t_wel();
    t_nowel();
    t_prot();
    t_busy();
    t_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule